// File: doc/BRIEF.md
# Uninitialized Register Pointer Guard

This block watches a 16-entry working register file and remembers, one bit per register, whether that register has received a full-word write since the last system reset. If the core uses a register that has not been written as an address pointer, the block asks for a device reset. In the same cycle it pulses a status line that sets the shared "bad opcode or bad pointer" cause flag.

It also screens fetched instruction words. A word whose top byte carries the reserved code raises the same reset request and the same status pulse. The top register, which serves as the stack pointer, is never tracked and always counts as written.

The block sits beside the register file and does not hold register contents. It sees only the write strobes, with their size indicator, the pointer-use strobes and the instruction screen strobe.

Top module: `uninit_ptr_guard`

## Requirements
- R1: While `rst_n` is low, `rst_req` and `flag_set` are 0. Every reset, including one taken after registers have been written, marks registers 0 to 14 as unwritten.
- R2: Register 15 always counts as written. A pointer use of index 15 never causes a request, with or without earlier writes.
- R3: A write with `wr_en`=1 and `wr_size`=1 (16-bit word) to index n marks register n as written from the next cycle on.
- R4: A write with `wr_size`=0 (byte) never marks a register, and two byte writes to one register, even in back-to-back cycles, leave it unwritten. A byte write to a register already marked leaves it marked.
- R5: A cycle with `ptr_en`=1 and `ptr_idx` naming an unwritten register drives `rst_req`=1 and `flag_set`=1 in the following cycle.
- R6: A cycle with `op_valid`=1 and `op_word[23:16]` equal to 8'h3F drives `rst_req`=1 and `flag_set`=1 in the following cycle. Other top-byte values, and any value while `op_valid`=0, cause nothing.
- R7: When a word write and a pointer use name the same register in one cycle, the use is judged on the state before the write. An unwritten register therefore faults, and the register counts as written from the next cycle.
- R8: `rst_req` and `flag_set` are high only in the cycle after a faulting cycle, and they are always equal. One faulting cycle gives one single-cycle pulse, even when a pointer fault and an opcode fault coincide.
- R9: While `ptr_en`=0, the value on `ptr_idx` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert |
| wr_en | input | 1 | Register file write strobe |
| wr_idx | input | 4 | Index of the register being written |
| wr_size | input | 1 | 1 = full 16-bit word write, 0 = byte write |
| ptr_en | input | 1 | Register is used as an address pointer this cycle |
| ptr_idx | input | 4 | Index of the register used as pointer |
| op_valid | input | 1 | Instruction word on `op_word` is being decoded |
| op_word | input | 24 | Fetched instruction word |
| rst_req | output | 1 | Registered single-cycle device reset request |
| flag_set | output | 1 | Registered pulse that sets the shared cause flag |

## Verification
A word write and a pointer use can name the same register in one cycle. The bench drives both strobes at once on a fresh register and expects a request, because the use sees the older state. It then repeats the use alone and expects silence. An illegal opcode and a pointer fault can also land in the same cycle. That case is judged by requiring exactly one pulse, followed by a quiet cycle, rather than a stretched or doubled request.

// File: rtl/upg_pkg.sv
package upg_pkg;

    localparam int unsigned REG_COUNT   = 16;
    localparam int unsigned INSN_WIDTH  = 24;
    localparam int unsigned OPC_WIDTH   = 8;
    localparam logic [7:0]  OPC_RESERVED = 8'h3F;

    // registered outputs of the request stage
    typedef struct packed {
        logic req;
        logic flag;
    } upg_pulse_t;

endpackage

// File: rtl/upg_init_map.sv
module upg_init_map #(
    parameter int unsigned NREGS = upg_pkg::REG_COUNT,
    parameter int unsigned IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_size,
    input  logic [IDX_W-1:0] ptr_idx,
    output logic [NREGS-1:0] init_vec,
    output logic             ptr_init
);

    localparam int unsigned EXEMPT = NREGS - 1;
    localparam logic [NREGS-1:0] RESET_MAP = NREGS'(1) << EXEMPT;

    typedef struct packed {
        logic [NREGS-1:0] marks;
    } map_state_t;

    map_state_t map_d, map_q;
    logic [NREGS-1:0] word_hit;

    // per-entry set strobe; the exempt entry is tied high
    for (genvar g = 0; g < NREGS; g++) begin : g_hit
        if (g == EXEMPT) begin : g_exempt
            assign word_hit[g] = 1'b1;
        end else begin : g_tracked
            assign word_hit[g] = wr_en & wr_size & (wr_idx == IDX_W'(g));
        end
    end

    always_comb begin
        map_d       = map_q;
        map_d.marks = map_q.marks | word_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '{marks: RESET_MAP};
        end else begin
            map_q <= map_d;
        end
    end

    assign init_vec = map_q.marks;
    assign ptr_init = map_q.marks[ptr_idx];

endmodule

// File: rtl/upg_op_screen.sv
module upg_op_screen #(
    parameter int unsigned INSN_W   = upg_pkg::INSN_WIDTH,
    parameter int unsigned OPC_W    = upg_pkg::OPC_WIDTH,
    parameter logic [OPC_W-1:0] BAD = upg_pkg::OPC_RESERVED
) (
    input  logic              op_valid,
    input  logic [INSN_W-1:0] op_word,
    output logic              op_bad
);

    logic [OPC_W-1:0] top_byte;
    logic             unused_low;

    assign top_byte   = op_word[INSN_W-1 -: OPC_W];
    assign unused_low = ^op_word[INSN_W-OPC_W-1:0];
    assign op_bad     = op_valid && (top_byte == BAD);

endmodule

// File: rtl/upg_req_pulse.sv
module upg_req_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic ptr_fault,
    input  logic op_fault,
    output logic rst_req,
    output logic flag_set
);

    upg_pkg::upg_pulse_t pls_d, pls_q;
    logic any_fault;

    always_comb begin
        any_fault  = ptr_fault | op_fault;
        pls_d.req  = any_fault;
        pls_d.flag = any_fault;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pls_q <= '0;
        end else begin
            pls_q <= pls_d;
        end
    end

    assign rst_req  = pls_q.req;
    assign flag_set = pls_q.flag;

endmodule

// File: rtl/uninit_ptr_guard.sv
module uninit_ptr_guard #(
    parameter int unsigned NREGS  = upg_pkg::REG_COUNT,
    parameter int unsigned INSN_W = upg_pkg::INSN_WIDTH,
    parameter int unsigned OPC_W  = upg_pkg::OPC_WIDTH,
    localparam int unsigned IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_size,
    input  logic              ptr_en,
    input  logic [IDX_W-1:0]  ptr_idx,
    input  logic              op_valid,
    input  logic [INSN_W-1:0] op_word,
    output logic              rst_req,
    output logic              flag_set
);

    logic [NREGS-1:0] init_vec;
    logic             ptr_init;
    logic             ptr_fault;
    logic             op_fault;

    upg_init_map #(.NREGS(NREGS), .IDX_W(IDX_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_size  (wr_size),
        .ptr_idx  (ptr_idx),
        .init_vec (init_vec),
        .ptr_init (ptr_init)
    );

    upg_op_screen #(.INSN_W(INSN_W), .OPC_W(OPC_W)) u_screen (
        .op_valid (op_valid),
        .op_word  (op_word),
        .op_bad   (op_fault)
    );

    // judged on the map before this cycle's write lands
    assign ptr_fault = ptr_en & ~ptr_init;

    upg_req_pulse u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_fault (ptr_fault),
        .op_fault  (op_fault),
        .rst_req   (rst_req),
        .flag_set  (flag_set)
    );

endmodule

// File: rtl/upg_checker.sv
module upg_checker #(
    parameter int unsigned NREGS  = 16,
    parameter int unsigned INSN_W = 24,
    parameter int unsigned IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              wr_size,
    input logic              ptr_en,
    input logic [IDX_W-1:0]  ptr_idx,
    input logic              op_valid,
    input logic [INSN_W-1:0] op_word,
    input logic              rst_req,
    input logic              flag_set,
    input logic [NREGS-1:0]  init_vec
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREGS - 1);

    // R1: outputs quiet while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!rst_req && !flag_set)
                else $error("a_r1_quiet_in_reset");
        end
    end

    // R2
    a_r2_top_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && ptr_idx == TOP_IDX && !op_valid) |=> !rst_req);

    // R3
    a_r3_word_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size) |=> init_vec[$past(wr_idx)]);

    // R4
    a_r4_byte_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_size && !init_vec[wr_idx]) |=> !init_vec[$past(wr_idx)]);

    // R5 / R7: judged on state seen in the use cycle
    a_r5_ptr_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && !init_vec[ptr_idx]) |=> (rst_req && flag_set));

    // R6
    a_r6_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_word[INSN_W-1 -: 8] == 8'h3F) |=> rst_req);

    // R8
    a_r8_no_cause_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_en && !op_valid) |=> !rst_req);

    a_r8_outputs_agree: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req == flag_set);

endmodule

bind uninit_ptr_guard upg_checker #(.NREGS(NREGS), .INSN_W(INSN_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_size  (wr_size),
    .ptr_en   (ptr_en),
    .ptr_idx  (ptr_idx),
    .op_valid (op_valid),
    .op_word  (op_word),
    .rst_req  (rst_req),
    .flag_set (flag_set),
    .init_vec (init_vec)
);

// File: tb/tb_uninit_ptr_guard.sv
`timescale 1ns/1ps
module tb_uninit_ptr_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic        wr_size = 1'b0;
    logic        ptr_en = 1'b0;
    logic [3:0]  ptr_idx = '0;
    logic        op_valid = 1'b0;
    logic [23:0] op_word = '0;
    logic        rst_req;
    logic        flag_set;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uninit_ptr_guard dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
        .ptr_en(ptr_en), .ptr_idx(ptr_idx), .op_valid(op_valid), .op_word(op_word),
        .rst_req(rst_req), .flag_set(flag_set)
    );

    typedef struct packed {
        logic       w1_en;  logic w1_word; logic [3:0] w1_idx;
        logic       w2_en;  logic w2_word; logic [3:0] w2_idx;
        logic       p_en;   logic [3:0] p_idx;
        logic       o_en;   logic [7:0] o_hi;
        logic       expect_req;
    } row_t;

    localparam int NROWS = 13;
    localparam row_t TBL [NROWS] = '{
        '{1'b0,1'b0,4'd0,  1'b0,1'b0,4'd0,  1'b1,4'd3,  1'b0,8'h00, 1'b1}, // R5 unwritten
        '{1'b1,1'b1,4'd3,  1'b0,1'b0,4'd0,  1'b1,4'd3,  1'b0,8'h00, 1'b0}, // R3 word marks
        '{1'b1,1'b0,4'd3,  1'b1,1'b0,4'd3,  1'b1,4'd3,  1'b0,8'h00, 1'b1}, // R4 two bytes
        '{1'b1,1'b1,4'd5,  1'b0,1'b0,4'd0,  1'b1,4'd3,  1'b0,8'h00, 1'b1}, // R3 other reg
        '{1'b0,1'b0,4'd0,  1'b0,1'b0,4'd0,  1'b1,4'd15, 1'b0,8'h00, 1'b0}, // R2 exempt
        '{1'b0,1'b0,4'd0,  1'b0,1'b0,4'd0,  1'b0,4'd0,  1'b1,8'h3F, 1'b1}, // R6 reserved
        '{1'b0,1'b0,4'd0,  1'b0,1'b0,4'd0,  1'b0,4'd0,  1'b1,8'h3E, 1'b0}, // R6 near miss
        '{1'b0,1'b0,4'd0,  1'b0,1'b0,4'd0,  1'b0,4'd0,  1'b0,8'h3F, 1'b0}, // R6 not valid
        '{1'b1,1'b1,4'd0,  1'b1,1'b0,4'd0,  1'b1,4'd0,  1'b0,8'h00, 1'b0}, // R4 byte keeps mark
        '{1'b1,1'b1,4'd14, 1'b0,1'b0,4'd0,  1'b1,4'd14, 1'b0,8'h00, 1'b0}, // R3 reg 14
        '{1'b0,1'b0,4'd0,  1'b0,1'b0,4'd0,  1'b0,4'd2,  1'b0,8'h00, 1'b0}, // R9 idle index
        '{1'b1,1'b0,4'd15, 1'b0,1'b0,4'd0,  1'b1,4'd15, 1'b1,8'hBF, 1'b0}, // R2 byte on 15
        '{1'b0,1'b0,4'd0,  1'b0,1'b0,4'd0,  1'b1,4'd15, 1'b1,8'h3F, 1'b1}  // R6 with exempt
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_size = 1'b0; wr_idx = '0;
        ptr_en = 1'b0; ptr_idx = '0; op_valid = 1'b0; op_word = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic word_wr(input logic [3:0] i);
        @(negedge clk); idle(); wr_en = 1'b1; wr_size = 1'b1; wr_idx = i;
    endtask

    task automatic use_ptr(input logic [3:0] i);
        @(negedge clk); idle(); ptr_en = 1'b1; ptr_idx = i;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1 quiet during reset
        @(negedge clk); @(negedge clk);
        chk("R1 req in reset", rst_req, 1'b0);
        chk("R1 flag in reset", flag_set, 1'b0);
        rst_n = 1'b1;

        for (int r = 0; r < NROWS; r++) begin
            do_reset();
            @(negedge clk); idle();
            wr_en = TBL[r].w1_en; wr_size = TBL[r].w1_word; wr_idx = TBL[r].w1_idx;
            @(negedge clk); idle();
            wr_en = TBL[r].w2_en; wr_size = TBL[r].w2_word; wr_idx = TBL[r].w2_idx;
            @(negedge clk); idle();
            ptr_en = TBL[r].p_en; ptr_idx = TBL[r].p_idx;
            op_valid = TBL[r].o_en; op_word = {TBL[r].o_hi, 16'h5A5A};
            @(negedge clk); idle();
            chk($sformatf("R5/R6 row %0d req", r), rst_req, TBL[r].expect_req);
            chk($sformatf("R8 row %0d flag", r), flag_set, TBL[r].expect_req);
            @(negedge clk);
            chk($sformatf("R8 row %0d pulse end", r), rst_req, 1'b0);
        end

        // R7 same-cycle word write and use
        do_reset();
        @(negedge clk); idle();
        wr_en = 1'b1; wr_size = 1'b1; wr_idx = 4'd6; ptr_en = 1'b1; ptr_idx = 4'd6;
        @(negedge clk); idle();
        chk("R7 same-cycle use faults", rst_req, 1'b1);
        use_ptr(4'd6);
        @(negedge clk); idle();
        chk("R7 marked after write", rst_req, 1'b0);

        // R1 reset clears marks already set
        do_reset();
        word_wr(4'd2);
        use_ptr(4'd2);
        @(negedge clk); idle();
        chk("R1 marked before reset", rst_req, 1'b0);
        do_reset();
        use_ptr(4'd2);
        @(negedge clk); idle();
        chk("R1 cleared by reset", rst_req, 1'b1);

        // R8 back-to-back faults give back-to-back pulses
        do_reset();
        use_ptr(4'd1);
        use_ptr(4'd1);
        @(negedge clk); idle();
        chk("R8 second pulse", rst_req, 1'b1);
        @(negedge clk);
        chk("R8 quiet after faults", rst_req, 1'b0);

        // R8 coinciding opcode and pointer faults: one pulse
        do_reset();
        @(negedge clk); idle();
        ptr_en = 1'b1; ptr_idx = 4'd4; op_valid = 1'b1; op_word = 24'h3F0000;
        @(negedge clk); idle();
        chk("R8 joint fault pulse", rst_req, 1'b1);
        chk("R8 joint fault flag", flag_set, 1'b1);
        @(negedge clk);
        chk("R8 joint fault single", rst_req, 1'b0);

        // R1/R3 every tracked register starts unwritten, then word writes mark all
        do_reset();
        for (int i = 0; i < 15; i++) begin
            use_ptr(4'(i));
            @(negedge clk); idle();
            chk($sformatf("R1 reg %0d unwritten", i), rst_req, 1'b1);
        end
        for (int i = 0; i < 15; i++) word_wr(4'(i));
        for (int i = 0; i < 16; i++) begin
            use_ptr(4'(i));
            @(negedge clk); idle();
            chk($sformatf("R3 reg %0d written", i), rst_req, 1'b0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule